// File: doc/BRIEF.md
# Resource-Shared Fixed-Point Weighted Summer

This block computes `d = 2.384·a + 0.0036·b + c` once per iteration. It is built for area, not throughput. It has one constant-gain multiplier and one adder, and a fixed four-step schedule shares both units across the two gains and the two additions. Every signal has its own two's-complement format (p, n). The value is a signed (n+1)-bit integer scaled by 2^(p−n), where p places the MSB relative to the binary point. Because of this, the muxes at the shared units also realign operands and results on each step.

To start an iteration, pulse `start` while the block is idle. The caller keeps `a_in`, `b_in` and `c_in` steady until `done`; the block does not store them. The scheduler runs four steps in dependency order, one per cycle:

1. gain on a, giving m1
2. gain on b, giving m2
3. m1 + m2, giving s1
4. s1 + c, giving s2

Each result goes into its own register. A one-cycle `done` pulse follows, and `d_out` (the s2 register) holds the result until the next iteration writes it again.

Default formats:

| Signal | Format (p, n) |
|---|---|
| a | (−1, 8) |
| b | (−1, 2) |
| c | (−1, 7) |
| m1 | (1, 9) |
| m2 | (−5, 3) |
| s1 | (1, 9) |
| s2 = d | (1, 8) |

The gains are 12-bit signed integers:

- 1221 scaled by 2^−9
- 1887 scaled by 2^−19

Top module: `wsum_fx`

## Requirements
- R1: While reset is asserted and after its release, `done` is 0 and `d_out` is 0.
- R2: The a-gain is m1 = floor(a_int·1221 / 2^10), kept as a 10-bit signed value, where a_int is `a_in` read as a 9-bit signed integer. Dropped LSBs truncate toward negative infinity.
- R3: The b-gain is m2 = floor(b_int·1887 / 2^14), kept as a 4-bit signed value, where b_int is `b_in` read as a 3-bit signed integer. For example, b_int = −4 gives m2 = −1 and b_int = 3 gives 0.
- R4: The second addition aligns c (8-bit signed, LSB weight 2^−8) with s1 (LSB weight 2^−8). It then drops one LSB to reach the s2 format, so c_int = 1 yields 0 and c_int = −1 yields −1.
- R5: `d_out` equals floor((s1 + c_int) / 2), kept as a 9-bit signed value, where s1 = m1 + m2 kept as a 10-bit signed value. The result is bit-exact for any legal inputs, and the four steps execute in the order m1, m2, s1, s2.
- R6: When `start` is sampled high at clock edge k while idle, `done` is high for exactly one cycle, from edge k+4 to edge k+5, and `d_out` carries the new result in that cycle.
- R7: A `start` sampled while an iteration is in progress, including the `done` cycle, is ignored: it produces no extra `done` and does not change the result.
- R8: `d_out` changes only when s2 is written and otherwise holds the last result. A `start` held high launches a new iteration every six cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an iteration when the block is idle |
| a_in | input | 9 | Signal a, format (−1,8), held through the iteration |
| b_in | input | 3 | Signal b, format (−1,2), held through the iteration |
| c_in | input | 8 | Signal c, format (−1,7), held through the iteration |
| d_out | output | 9 | Result d, format (1,8) |
| done | output | 1 | One-cycle pulse when `d_out` is new |

## Verification
The bench targets the rounding direction on negative values, such as a = −255, b = −4 and c = −1. A design that rounded toward zero, or that misaligned the b operand or the s2 output, would be off by one LSB or by a power of two in `d_out`. Full-scale positive and negative a check that the m1 register keeps its top bits; a wrong output-alignment offset in the shared multiplier would wrap or halve the value. Holding `start` high through the busy and `done` cycles targets re-entry: a design that restarted would pulse `done` early or twice. Idle gaps with changing inputs expose a `d_out` that follows the live inputs instead of holding.

// File: rtl/wsum_pkg.sv
package wsum_pkg;

  localparam int FX_WORK_W = 48;

  typedef logic signed [FX_WORK_W-1:0] fx_word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_M1,
    ST_M2,
    ST_S1,
    ST_S2,
    ST_DONE
  } wsum_state_e;

  // Exponent of the LSB weight of a (p,n) format.
  function automatic int fx_lsb(input int p, input int n);
    return p - n;
  endfunction

  // Move a value from one LSB exponent to another (floor on right shifts),
  // then wrap to to_w bits and sign-extend back to the working width.
  function automatic fx_word_t fx_requant(input fx_word_t x, input int from_e,
                                          input int to_e, input int to_w);
    fx_word_t t;
    int sh;
    sh = to_e - from_e;
    if (sh >= 0) t = x >>> sh;
    else         t = x <<< (-sh);
    t = (t <<< (FX_WORK_W - to_w)) >>> (FX_WORK_W - to_w);
    return t;
  endfunction

endpackage

// File: rtl/wsum_sched.sv
module wsum_sched
  import wsum_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic wr_m1,
  output logic wr_m2,
  output logic wr_s1,
  output logic wr_s2,
  output logic sel_b,
  output logic sel_c,
  output logic busy,
  output logic done
);

  wsum_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_M1;
      ST_M1:   state_d = ST_M2;
      ST_M2:   state_d = ST_S1;
      ST_S1:   state_d = ST_S2;
      ST_S2:   state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Register enables and mux selects come straight from the schedule.
  assign wr_m1 = (state_q == ST_M1);
  assign wr_m2 = (state_q == ST_M2);
  assign wr_s1 = (state_q == ST_S1);
  assign wr_s2 = (state_q == ST_S2);
  assign sel_b = (state_q == ST_M2);
  assign sel_c = (state_q == ST_S2);
  assign busy  = (state_q != ST_IDLE);
  assign done  = (state_q == ST_DONE);

endmodule

// File: rtl/wsum_gain.sv
module wsum_gain
  import wsum_pkg::*;
#(
  parameter int A_P     = -1,
  parameter int A_N     = 8,
  parameter int B_P     = -1,
  parameter int B_N     = 2,
  parameter int M1_P    = 1,
  parameter int M1_N    = 9,
  parameter int M2_P    = -5,
  parameter int M2_N    = 3,
  parameter int COEF_W  = 12,
  parameter int G1_VAL  = 1221,
  parameter int G1_FRAC = 9,
  parameter int G2_VAL  = 1887,
  parameter int G2_FRAC = 19
) (
  input  logic           sel_b,
  input  logic [A_N:0]   a_in,
  input  logic [B_N:0]   b_in,
  output fx_word_t       y
);

  localparam int A_W   = A_N + 1;
  localparam int B_W   = B_N + 1;
  localparam int M1_W  = M1_N + 1;
  localparam int M2_W  = M2_N + 1;
  localparam int OPD_W = (A_W > B_W) ? A_W : B_W;
  // Operands are MSB-aligned onto a common OPD_W-bit port (zero padding).
  localparam int A_E   = fx_lsb(A_P, A_N) - (OPD_W - A_W);
  localparam int B_E   = fx_lsb(B_P, B_N) - (OPD_W - B_W);
  localparam int PA_E  = A_E - G1_FRAC;
  localparam int PB_E  = B_E - G2_FRAC;
  localparam int M1_E  = fx_lsb(M1_P, M1_N);
  localparam int M2_E  = fx_lsb(M2_P, M2_N);

  localparam logic signed [COEF_W-1:0] G1 = G1_VAL[COEF_W-1:0];
  localparam logic signed [COEF_W-1:0] G2 = G2_VAL[COEF_W-1:0];

  fx_word_t opd_a, opd_b, opd, coef, prod;

  always_comb begin
    opd_a = fx_word_t'($signed(a_in)) <<< (OPD_W - A_W);
    opd_b = fx_word_t'($signed(b_in)) <<< (OPD_W - B_W);
    opd   = sel_b ? opd_b : opd_a;
    coef  = sel_b ? fx_word_t'(G2) : fx_word_t'(G1);
    prod  = opd * coef;
    y     = sel_b ? fx_requant(prod, PB_E, M2_E, M2_W)
                  : fx_requant(prod, PA_E, M1_E, M1_W);
  end

endmodule

// File: rtl/wsum_adder.sv
module wsum_adder
  import wsum_pkg::*;
#(
  parameter int M1_P = 1,
  parameter int M1_N = 9,
  parameter int M2_P = -5,
  parameter int M2_N = 3,
  parameter int S1_P = 1,
  parameter int S1_N = 9,
  parameter int C_P  = -1,
  parameter int C_N  = 7,
  parameter int S2_P = 1,
  parameter int S2_N = 8
) (
  input  logic          sel_c,
  input  logic [M1_N:0] m1,
  input  logic [M2_N:0] m2,
  input  logic [S1_N:0] s1,
  input  logic [C_N:0]  c_in,
  output fx_word_t      y
);

  localparam int M1_E = fx_lsb(M1_P, M1_N);
  localparam int M2_E = fx_lsb(M2_P, M2_N);
  localparam int S1_E = fx_lsb(S1_P, S1_N);
  localparam int C_E  = fx_lsb(C_P, C_N);
  localparam int S2_E = fx_lsb(S2_P, S2_N);
  localparam int S1_W = S1_N + 1;
  localparam int S2_W = S2_N + 1;
  // Common operand exponent per step: the finer of the two inputs.
  localparam int J0_E = (M1_E < M2_E) ? M1_E : M2_E;
  localparam int J1_E = (S1_E < C_E)  ? S1_E : C_E;

  fx_word_t opx, opy, sum;

  always_comb begin
    if (!sel_c) begin
      opx = fx_requant(fx_word_t'($signed(m1)), M1_E, J0_E, FX_WORK_W);
      opy = fx_requant(fx_word_t'($signed(m2)), M2_E, J0_E, FX_WORK_W);
    end else begin
      opx = fx_requant(fx_word_t'($signed(s1)), S1_E, J1_E, FX_WORK_W);
      opy = fx_requant(fx_word_t'($signed(c_in)), C_E, J1_E, FX_WORK_W);
    end
    sum = opx + opy;
    y   = sel_c ? fx_requant(sum, J1_E, S2_E, S2_W)
                : fx_requant(sum, J0_E, S1_E, S1_W);
  end

endmodule

// File: rtl/wsum_fx.sv
module wsum_fx
  import wsum_pkg::*;
#(
  parameter int A_P     = -1,
  parameter int A_N     = 8,
  parameter int B_P     = -1,
  parameter int B_N     = 2,
  parameter int C_P     = -1,
  parameter int C_N     = 7,
  parameter int M1_P    = 1,
  parameter int M1_N    = 9,
  parameter int M2_P    = -5,
  parameter int M2_N    = 3,
  parameter int S1_P    = 1,
  parameter int S1_N    = 9,
  parameter int S2_P    = 1,
  parameter int S2_N    = 8,
  parameter int COEF_W  = 12,
  parameter int G1_VAL  = 1221,
  parameter int G1_FRAC = 9,
  parameter int G2_VAL  = 1887,
  parameter int G2_FRAC = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [A_N:0]  a_in,
  input  logic [B_N:0]  b_in,
  input  logic [C_N:0]  c_in,
  output logic [S2_N:0] d_out,
  output logic          done
);

  localparam int M1_W = M1_N + 1;
  localparam int M2_W = M2_N + 1;
  localparam int S1_W = S1_N + 1;
  localparam int S2_W = S2_N + 1;

  logic wr_m1, wr_m2, wr_s1, wr_s2, sel_b, sel_c, busy;
  fx_word_t gain_y, add_y;

  logic [M1_W-1:0] m1_q;
  logic [M2_W-1:0] m2_q;
  logic [S1_W-1:0] s1_q;
  logic [S2_W-1:0] s2_q;

  wsum_sched u_sched (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .wr_m1 (wr_m1),
    .wr_m2 (wr_m2),
    .wr_s1 (wr_s1),
    .wr_s2 (wr_s2),
    .sel_b (sel_b),
    .sel_c (sel_c),
    .busy  (busy),
    .done  (done)
  );

  wsum_gain #(
    .A_P(A_P), .A_N(A_N), .B_P(B_P), .B_N(B_N),
    .M1_P(M1_P), .M1_N(M1_N), .M2_P(M2_P), .M2_N(M2_N),
    .COEF_W(COEF_W), .G1_VAL(G1_VAL), .G1_FRAC(G1_FRAC),
    .G2_VAL(G2_VAL), .G2_FRAC(G2_FRAC)
  ) u_gain (
    .sel_b (sel_b),
    .a_in  (a_in),
    .b_in  (b_in),
    .y     (gain_y)
  );

  wsum_adder #(
    .M1_P(M1_P), .M1_N(M1_N), .M2_P(M2_P), .M2_N(M2_N),
    .S1_P(S1_P), .S1_N(S1_N), .C_P(C_P), .C_N(C_N),
    .S2_P(S2_P), .S2_N(S2_N)
  ) u_adder (
    .sel_c (sel_c),
    .m1    (m1_q),
    .m2    (m2_q),
    .s1    (s1_q),
    .c_in  (c_in),
    .y     (add_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_q <= '0;
      m2_q <= '0;
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      if (wr_m1) m1_q <= gain_y[M1_W-1:0];
      if (wr_m2) m2_q <= gain_y[M2_W-1:0];
      if (wr_s1) s1_q <= add_y[S1_W-1:0];
      if (wr_s2) s2_q <= add_y[S2_W-1:0];
    end
  end

  assign d_out = s2_q;

endmodule

// File: rtl/wsum_fx_chk.sv
module wsum_fx_chk #(
  parameter int D_W = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           done,
  input logic [D_W-1:0] d_out,
  input logic           busy,
  input logic           wr_m1,
  input logic           wr_m2,
  input logic           wr_s1,
  input logic           wr_s2
);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_s2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s2 |=> done);

  assert_steps_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_m1, wr_m2, wr_s1, wr_s2, done}));

  assert_order_m2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_m2 |-> $past(wr_m1));

  assert_order_s1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s1 |-> $past(wr_m2));

  assert_order_s2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s2 |-> $past(wr_s1));

  assert_accept_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> !wr_m1);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_s2 |=> $stable(d_out));

endmodule

bind wsum_fx wsum_fx_chk #(.D_W(S2_N + 1)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .done  (done),
  .d_out (d_out),
  .busy  (busy),
  .wr_m1 (wr_m1),
  .wr_m2 (wr_m2),
  .wr_s1 (wr_s1),
  .wr_s2 (wr_s2)
);

// File: tb/wsum_fx_tb.sv
module wsum_fx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] a_in = '0;
  logic [2:0] b_in = '0;
  logic [7:0] c_in = '0;
  logic [8:0] d_out;
  logic       done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wsum_fx u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .a_in  (a_in),
    .b_in  (b_in),
    .c_in  (c_in),
    .d_out (d_out),
    .done  (done)
  );

  function automatic int wrapw(input int v, input int w);
    int m;
    m = v & ((1 << w) - 1);
    if (m >= (1 << (w - 1))) m = m - (1 << w);
    return m;
  endfunction

  // Reference: integer arithmetic with floor division, per-signal wrap.
  function automatic int ref_d(input int a, input int b, input int c);
    int m1, m2, s1;
    m1 = wrapw((a * 1221) >>> 10, 10);
    m2 = wrapw((b * 1887) >>> 14, 4);
    s1 = wrapw(m1 + m2, 10);
    return wrapw((s1 + c) >>> 1, 9);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle model of the schedule.
  int    phase = 0;
  int    pend = 0;
  int    last_exp = 0;
  string cur_tag = "R5";
  string pend_tag = "R5";
  string last_tag = "R5";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0;
      last_exp = 0;
    end else if (phase == 0) begin
      if (start) begin
        phase = 1;
        pend = ref_d($signed(a_in), $signed(b_in), $signed(c_in));
        pend_tag = cur_tag;
      end
    end else if (phase == 5) begin
      phase = 0;
    end else begin
      phase = phase + 1;
      if (phase == 5) begin
        last_exp = pend;
        last_tag = pend_tag;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check(done == 1'b0, "R1 done in reset", int'(done), 0);
      check(d_out == 9'd0, "R1 d in reset", int'(d_out), 0);
    end else begin
      check(done == (phase == 5), "R6 done timing", int'(done), int'(phase == 5));
      if (phase == 5)
        check($signed(d_out) == last_exp, last_tag, $signed(d_out), last_exp);
      else
        check($signed(d_out) == last_exp, "R8 hold", $signed(d_out), last_exp);
    end
  end

  task automatic run(input int a, input int b, input int c, input string tag);
    @(negedge clk);
    a_in = a[8:0];
    b_in = b[2:0];
    c_in = c[7:0];
    cur_tag = tag;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(0, 0, 0, "R5 zero");
    run(255, 0, 0, "R2 a max");
    run(-255, 0, 0, "R2 a min");
    run(100, 0, 0, "R2 a mid");
    run(-1, 0, 0, "R2 a neg lsb");
    run(0, -4, 0, "R3 b min");
    run(0, 3, 0, "R3 b max");
    run(0, -1, 0, "R3 b neg");
    run(0, 0, 127, "R4 c max");
    run(0, 0, -128, "R4 c min");
    run(0, 0, 1, "R4 c pos lsb");
    run(0, 0, -1, "R4 c neg lsb");
    run(255, 3, 127, "R5 all max");
    run(-255, -4, -128, "R5 all min");
    run(-37, 2, 91, "R5 mixed a");
    run(200, -3, -77, "R5 mixed b");

    // R7: start kept high through the busy and done cycles.
    @(negedge clk);
    a_in = 9'd123; b_in = 3'd1; c_in = 8'd45;
    cur_tag = "R7 start while busy";
    start = 1'b1;
    repeat (6) @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);

    // R8: continuous start gives back-to-back iterations every six cycles.
    a_in = 9'h1A5; b_in = 3'd6; c_in = 8'hC3;
    cur_tag = "R8 back to back";
    start = 1'b1;
    repeat (18) @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);

    // R8: inputs move while idle; d must hold.
    a_in = 9'd77; b_in = 3'd2; c_in = 8'd10;
    repeat (8) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule